// File: doc/BRIEF.md
# One-Shot Tick Delay Timer

This block is a single-channel countdown timer that software uses to wait for a fixed delay. A synchronous register port reaches two 32-bit words. The control word holds a 16-bit period and a run bit. The event word holds a sticky expiry flag and an interrupt mask.

Software writes a period with the run bit set. The block then counts down that many fixed 640 ns ticks. An internal prescaler derives the ticks from the system clock. When the count is used up, the block sets the expiry flag, clears the run bit and stops. Software either polls the flag or takes the interrupt line, and clears the flag by writing a 1 to it.

The sequencer has two states:
- `ST_IDLE` — waiting.
- `ST_RUN` — counting.

Its transitions are:
- *arm*: from `ST_IDLE` to `ST_RUN` on a control write with the run bit set.
- *rearm*: from `ST_RUN` back to `ST_RUN` on such a write, reloading the new period.
- *step*: from `ST_RUN` to `ST_RUN` on a tick while more than one tick remains.
- *expire*: from `ST_RUN` to `ST_IDLE` on the last tick, setting the flag.
- *abort*: from `ST_RUN` to `ST_IDLE` on a control write with the run bit clear, without setting the flag.

Top module: `tick_delay_timer`

## Requirements
- R1: After reset the control word (word 0) reads 0x0000FFFF: period 0xFFFF in bits [15:0] and run bit 16 clear. The event word (word 1) reads 0 and `irq` is low.
- R2: A write to word 0 stores bits [15:0] as the period, and reads of word 0 return that period. Bit 16 of word 0 reads 1 exactly while a countdown is in progress.
- R3: One tick lasts TICK_PS/CLK_PERIOD_PS clock cycles, which is 64 cycles at the defaults. The expiry flag (bit 1 of word 1) becomes 1 exactly max(P,1)×64 cycles after the clock edge that accepts a word-0 write of period P with bit 16 set, and not earlier.
- R4: On expiry the count stops and bit 16 of word 0 reads 0. No further expiry occurs until software writes bit 16 again.
- R5: The expiry flag is sticky. Writing word 1 with bit 1 set clears it, and writing bit 1 as 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R6: Bit 16 of word 1 is the mask and reads back as written. `irq` is high exactly when the flag is set and the mask is clear.
- R7: A word-0 write with bit 16 clear during a countdown aborts it: the flag stays clear and bit 16 reads 0.
- R8: A word-0 write with bit 16 set during a countdown restarts it, including the prescaler phase, with the newly written period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Word address: 0 selects the control word, 1 selects the event word, other values are unmapped |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| irq | output | 1 | Interrupt request: expiry flag with the mask applied |

## Verification
The bench sweeps the period from 0 to 5 with the mask both clear and set. For each period it samples the flag one cycle before and exactly at the predicted expiry edge. A prescaler that is off by one, or a design that treats a period of 0 as 65536 ticks, fails at one of those two points.

Three further runs check that an update does not leave stale state behind:
- A restart in mid-count must take its timing from the second write. A design that keeps the old prescaler phase or the old count expires early.
- An abort must leave the flag clear, even well after the original deadline has passed.
- After expiry, a cleared flag must stay clear. A design that reloads automatically would raise it again.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tdt_state_e;

    localparam int CTRL_WORD   = 0;
    localparam int EVENT_WORD  = 1;
    localparam int RUN_BIT     = 16;
    localparam int FLAG_BIT    = 1;
    localparam int MASK_BIT    = 16;
endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && !restart && (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R3
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tdt_fsm.sv
module tdt_fsm
    import tdt_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                abort,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                running,
    output logic                expire
);
    tdt_state_e          state_q, state_d;
    logic [PERIOD_W-1:0] rem_q, rem_d;
    logic                last_tick;

    assign last_tick = (rem_q <= PERIOD_W'(1));

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    rem_d   = period;
                end
            end
            ST_RUN: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (start) begin
                    rem_d = period;
                end else if (tick) begin
                    if (last_tick) begin
                        state_d = ST_IDLE;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        running = (state_q == ST_RUN);
        expire  = (state_q == ST_RUN) && tick && last_tick && !abort && !start;
    end

    // R3
    rem_nonincr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !start && !abort) |=> (rem_q <= $past(rem_q)));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));
    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tick_delay_timer.sv
module tick_delay_timer
    import tdt_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int TICK_PS       = 640000,
    parameter int ADDR_W        = 2,
    parameter int PERIOD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int TICK_DIV = (TICK_PS / CLK_PERIOD_PS > 0) ? TICK_PS / CLK_PERIOD_PS : 1;

    logic [PERIOD_W-1:0] period_q;
    logic                flag_q, mask_q;
    logic                wr_ctrl, wr_event, start, abort;
    logic                tick, running, expire;

    assign wr_ctrl  = bus_wr_en && (bus_addr == ADDR_W'(CTRL_WORD));
    assign wr_event = bus_wr_en && (bus_addr == ADDR_W'(EVENT_WORD));
    assign start    = wr_ctrl && bus_wdata[RUN_BIT];
    assign abort    = wr_ctrl && !bus_wdata[RUN_BIT];

    tdt_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (start),
        .tick    (tick)
    );

    tdt_fsm #(.PERIOD_W(PERIOD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (abort),
        .tick    (tick),
        .period  (bus_wdata[PERIOD_W-1:0]),
        .running (running),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
            flag_q   <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                period_q <= bus_wdata[PERIOD_W-1:0];
            end
            if (wr_event) begin
                mask_q <= bus_wdata[MASK_BIT];
            end
            if (expire) begin
                flag_q <= 1'b1;
            end else if (wr_event && bus_wdata[FLAG_BIT]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_WORD)) begin
            bus_rdata[PERIOD_W-1:0] = period_q;
            bus_rdata[RUN_BIT]      = running;
        end else if (bus_addr == ADDR_W'(EVENT_WORD)) begin
            bus_rdata[FLAG_BIT] = flag_q;
            bus_rdata[MASK_BIT] = mask_q;
        end
        irq = flag_q && !mask_q;
    end

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_event && bus_wdata[FLAG_BIT])) |=> flag_q);
    // R7
    abort_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !flag_q) |=> !flag_q);
    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq);
    // R4
    flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(running));
endmodule

// File: tb/tick_delay_timer_tb.sv
module tick_delay_timer_tb_top;
    localparam int DIV = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_delay_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // write: leaves time 1 ns after the accepting edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // advance so that state after the n-th edge since the last write edge is visible
    task automatic to_edge(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 32'h0000_FFFF);
        rd(2'd1, d); check("R1 event", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3 R6 R2 sweep of period and mask
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 6; p++) begin
                int n;
                n = ((p < 1) ? 1 : p) * DIV;
                wr(2'd1, {15'b0, m[0], 14'b0, 1'b1, 1'b0});
                wr(2'd0, {15'b0, 1'b1, 16'(p)});
                #1;
                rd(2'd0, d); check("R2 running", d, {15'b0, 1'b1, 16'(p)});
                to_edge(n - 1);
                rd(2'd1, d); check("R3 early", d, {15'b0, m[0], 16'h0});
                to_edge(1);
                rd(2'd1, d); check("R3 expiry", d, {15'b0, m[0], 14'b0, 2'b10});
                check("R6 irq", {31'b0, irq}, {31'b0, ~m[0]});
                rd(2'd0, d); check("R4 stopped", d, {16'h0, 16'(p)});
            end
        end

        // R5 write 0 keeps, write 1 clears
        wr(2'd1, 32'h0);
        #1; rd(2'd1, d); check("R5 keep", d, 32'h2);
        check("R6 irq on", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h2);
        #1; rd(2'd1, d); check("R5 clear", d, 32'h0);
        check("R6 irq off", {31'b0, irq}, 32'h0);

        // R4 no reload after expiry
        wr(2'd0, {15'b0, 1'b1, 16'd1});
        to_edge(DIV);
        wr(2'd1, 32'h2);
        to_edge(4 * DIV);
        rd(2'd1, d); check("R4 no reload", d, 32'h0);

        // R7 abort mid-count
        wr(2'd0, {15'b0, 1'b1, 16'd3});
        to_edge(100);
        wr(2'd0, {16'h0, 16'd3});
        to_edge(4 * DIV);
        rd(2'd1, d); check("R7 no flag", d, 32'h0);
        rd(2'd0, d); check("R7 run bit", d, 32'h0000_0003);

        // R8 restart mid-count
        wr(2'd0, {15'b0, 1'b1, 16'd4});
        to_edge(100);
        wr(2'd0, {15'b0, 1'b1, 16'd2});
        to_edge(2 * DIV - 1);
        rd(2'd1, d); check("R8 early", d, 32'h0);
        to_edge(1);
        rd(2'd1, d); check("R8 expiry", d, 32'h2);
        rd(2'd0, d); check("R8 period", d, 32'h0000_0002);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule